// File: doc/BRIEF.md
# Programmable Pixel Clock Frequency Calculator

This block works out the frequency, in hertz, of the pixel clock that a display controller's clock synthesiser would produce for the current settings. It takes four programmable multiplier/divider byte pairs, a memory-clock settings byte and the two-bit clock-select field. From these it forms a 32-bit dividend, which is the fixed 14,318,181 Hz reference times a multiplier, and an 8-bit divisor. A bit-serial restoring divider then produces the quotient.

A pulse on `start_i` samples every input. Exactly 32 clock cycles later, `freq_o` holds the result and `done_o` rises. Both then stay unchanged until the next start. The register file that holds the settings lives outside the block. Its power-on settings are multipliers 0x66, 0x5B, 0x45, 0x7E, dividers 0x3B, 0x2F, 0x30, 0x33 and memory-clock byte 0x1C, and the bench uses these as its first stimulus set. In the memory-clock-derived mode the shift right by 3 or by 4 is carried out as a division by 8 or 16 on the same divider. This keeps the latency the same in every mode.

Top module: `pixclk_calc`

## Requirements
- R1: With `mclk_cfg_i[6]` = 0, `clk_sel_i` value s (0..3) selects pair s: multiplier `mult_i[s]` and divider `div_i[s]`.
- R2: Bit 7 of the selected multiplier is ignored; only bits 6:0 multiply the reference.
- R3: When bit 7 of the selected divider is 0, bit 6 of that divider is treated as 0.
- R4: After the R3 masking, if divider bit 0 is 1, the effective divisor is the value with bit 0 cleared; otherwise it is the value shifted right by one.
- R5: In the pair mode, `freq_o` = floor(14318181 × multiplier / effective divisor), truncated to 32 bits.
- R6: When `mclk_cfg_i[6]` = 1, `freq_o` = floor(14318181 × `mclk_cfg_i[5:0]` / 8), whatever `clk_sel_i` and `mclk_cfg_i[7]` are.
- R7: In the R6 mode, if `div_i[3][0]` = 1 the result is halved again, giving floor(14318181 × `mclk_cfg_i[5:0]` / 16).
- R8: An effective divisor of zero gives `freq_o` = 0.
- R9: `done_o` rises, and `freq_o` takes its new value, on the 32nd rising edge after the edge that samples `start_i` = 1.
- R10: The edge that samples `start_i` = 1 clears `done_o`. Apart from that, `done_o` and `freq_o` are held unchanged until the next start.
- R11: While `rst_n` is low, `done_o` and `freq_o` are 0.
- R12: Inputs are sampled only at the start edge; changes while a computation runs do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sample the settings and begin a computation |
| clk_sel_i | input | 2 | Clock-select field choosing one of the four pairs |
| mult_i | input | 4x8 | Multiplier bytes, one per pair |
| div_i | input | 4x8 | Divider bytes, one per pair |
| mclk_cfg_i | input | 8 | Memory-clock byte: bit 6 selects the derived mode, bits 5:0 are its multiplier |
| freq_o | output | 32 | Computed frequency in Hz |
| done_o | output | 1 | Result valid; held until the next start |

## Verification
The divider's state is internal, so any fault in it can only show up as a wrong value in `freq_o` or a `done_o` edge at the wrong time. Both appear exactly 32 cycles after the start. A wrong remainder or a bad quotient shift corrupts low-order bits of the result, so the bench compares every result bit-exactly against a model of the requirements. An off-by-one in the step counter moves the `done_o` edge by one cycle, so the bench checks the cycle in which that edge appears. A wrong choice of pair or a divider field masked the wrong way changes the result by a large factor, and a small set of hand-picked divider bytes reaches every masking branch.

// File: rtl/pixclk_calc.sv
module pixclk_calc #(
  parameter int unsigned REF_HZ = 14318181,
  parameter int FW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       clk_sel_i,
  input  logic [3:0][7:0]  mult_i,
  input  logic [3:0][7:0]  div_i,
  input  logic [7:0]       mclk_cfg_i,
  output logic [FW-1:0]    freq_o,
  output logic             done_o
);
  localparam int CW = $clog2(FW);
  localparam logic [FW-1:0] REF_V = FW'(REF_HZ);

  logic [7:0]    sel_mult, sel_div, div_masked, div_eff, mult_use, divisor;
  logic [FW+7:0] prod;
  logic          mclk_mode;

  assign sel_mult   = mult_i[clk_sel_i];
  assign sel_div    = div_i[clk_sel_i];
  assign div_masked = sel_div[7] ? sel_div : {sel_div[7], 1'b0, sel_div[5:0]};
  assign div_eff    = div_masked[0] ? {div_masked[7:1], 1'b0} : {1'b0, div_masked[7:1]};
  assign mclk_mode  = mclk_cfg_i[6];
  assign mult_use   = mclk_mode ? {2'b00, mclk_cfg_i[5:0]} : {1'b0, sel_mult[6:0]};
  assign divisor    = mclk_mode ? (div_i[3][0] ? 8'd16 : 8'd8) : div_eff;
  assign prod       = {8'b0, REF_V} * {{FW{1'b0}}, mult_use};

  logic [FW-1:0] quo;
  logic [7:0]    rem, dvs;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [8:0]    trial;
  logic          ge;
  logic [FW-1:0] quo_next;

  assign trial    = {rem, quo[FW-1]};
  assign ge       = trial >= {1'b0, dvs};
  assign quo_next = {quo[FW-2:0], ge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo    <= '0;
      rem    <= '0;
      dvs    <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      done_o <= 1'b0;
      freq_o <= '0;
    end else if (start_i) begin
      quo    <= prod[FW-1:0];
      rem    <= '0;
      dvs    <= divisor;
      cnt    <= '0;
      busy   <= 1'b1;
      done_o <= 1'b0;
    end else if (busy) begin
      quo <= quo_next;
      rem <= ge ? 8'(trial - {1'b0, dvs}) : trial[7:0];
      cnt <= cnt + 1'b1;
      if (cnt == CW'(FW - 1)) begin
        busy   <= 1'b0;
        done_o <= 1'b1;
        freq_o <= (dvs == 8'd0) ? '0 : quo_next;
      end
    end
  end
endmodule

module pixclk_calc_chk #(
  parameter int FW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          done_o,
  input logic [FW-1:0] freq_o
);
  logic [15:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else if (start_i) lat <= '0;
    else if (!done_o && lat != 16'hFFFF) lat <= lat + 1'b1;
  end

  // R10
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(freq_o)));

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (lat == 16'(FW)));

  // R9
  freq_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_o) |-> $rose(done_o));
endmodule

bind pixclk_calc pixclk_calc_chk #(.FW(FW)) u_pixclk_calc_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .freq_o(freq_o)
);

// File: tb/test_pixclk_calc.sv
module test_pixclk_calc;
  localparam int FW = 32;
  localparam longint REF = 14318181;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      sel = 2'd0;
  logic [3:0][7:0] mult, dv;
  logic [7:0]      mcfg;
  logic [FW-1:0]   freq;
  logic            done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct { longint exp; int at; string tag; } item_t;
  item_t sb[$];

  pixclk_calc i_pixclk_calc (
    .clk(clk), .rst_n(rst_n), .start_i(start), .clk_sel_i(sel),
    .mult_i(mult), .div_i(dv), .mclk_cfg_i(mcfg), .freq_o(freq), .done_o(done)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint model();
    logic [7:0] d;
    longint n;
    if (mcfg[6]) return (REF * longint'(mcfg[5:0])) / (dv[3][0] ? 16 : 8);
    n = longint'(mult[sel] & 8'h7F);
    d = dv[sel];
    if (!d[7]) d[6] = 1'b0;
    d = d[0] ? (d & 8'hFE) : (d >> 1);
    if (d == 0) return 0;
    return ((REF * n) / longint'(d)) & 64'hFFFF_FFFF;
  endfunction

  task automatic defaults();
    mult = {8'h7E, 8'h45, 8'h5B, 8'h66};
    dv   = {8'h33, 8'h30, 8'h2F, 8'h3B};
    mcfg = 8'h1C;
    sel  = 2'd0;
  endtask

  task automatic go(string tag, bit scramble);
    logic [FW-1:0] held;
    item_t it;
    @(negedge clk);
    start = 1'b1;
    it.exp = model(); it.at = cyc + 1 + FW; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, {tag, "/R10 start clears done"}, done, 0);
    if (scramble) begin
      mult = {$urandom, $urandom}; dv = {$urandom, $urandom};
      mcfg = 8'($urandom); sel = 2'($urandom);
    end
    wait (sb.size() == 0);
    @(negedge clk);
    held = freq;
    repeat (3) @(negedge clk);
    check(done == 1'b1 && freq == held, {tag, "/R10 hold"}, freq, held);
  endtask

  logic done_q = 1'b0;
  always @(negedge clk) begin
    if (done && !done_q) begin
      if (sb.size() == 0) check(1'b0, "R9 unexpected done", 1, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(longint'(freq) == it.exp, it.tag, freq, it.exp);
        check(cyc == it.at, {it.tag, "/R9 latency"}, cyc, it.at);
      end
    end
    done_q = done;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    // R11
    check(done == 1'b0, "R11 done in reset", done, 0);
    check(freq == '0, "R11 freq in reset", freq, 0);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      go($sformatf("R1 pair %0d", s), 1'b0);
    end
    defaults();

    mult[0] = 8'hE6; go("R2 multiplier bit7 ignored", 1'b0);
    defaults();
    dv[0] = 8'h7B; go("R3 divider bit6 masked", 1'b0);
    dv[0] = 8'hC3; go("R3 divider bit6 kept", 1'b0);
    dv[0] = 8'h20; go("R4 shift path", 1'b0);
    dv[0] = 8'hFF; go("R4 clear bit0 path", 1'b0);
    mult[0] = 8'h7F; dv[0] = 8'h82; go("R5 max multiplier", 1'b0);
    mult[0] = 8'h01; dv[0] = 8'h05; go("R5 small ratio", 1'b0);
    defaults();

    mcfg = 8'h5C; dv[3] = 8'h32; sel = 2'd1; go("R6 memory-clock mode", 1'b0);
    mcfg = 8'hFF; sel = 2'd2; go("R6 bit7 ignored", 1'b0);
    mcfg = 8'h5C; dv[3] = 8'h33; go("R7 halved", 1'b0);
    defaults();

    dv[0] = 8'h01; go("R8 zero divisor bit0", 1'b0);
    dv[0] = 8'h00; go("R8 zero divisor", 1'b0);
    dv[0] = 8'h40; go("R8 masked to zero", 1'b0);
    defaults();

    sel = 2'd3; go("R12 inputs changed mid-run", 1'b1);
    defaults();
    mcfg = 8'h7F; dv[3] = 8'h01; go("R12 mode inputs changed mid-run", 1'b1);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule